// File: doc/BRIEF.md
# Receive Queue with Level-Triggered Interrupts

This block holds received characters in a small first-in first-out queue and raises one interrupt line when the queue occupancy meets a programmed trigger point. A receiver pushes characters in; a reader pops them out in arrival order. The reader also sees the current occupancy, a not-empty flag and a full flag. A one-cycle flush strobe discards everything that is queued.

Each direction has its own trigger logic. The receive side fires as data builds up. The transmit side uses the same occupancy count and fires as the count drops toward empty. A trigger point is a 4-bit code, and only three code values are meaningful. Each direction also has an interrupt-enable bit. A set strobe can only turn that bit on, and a separate clear strobe can only turn it off. A direction's masked status is its enable bit ANDed with its trigger condition. The interrupt output is the OR of the two masked statuses. Every output is a combinational function of registered state, so it follows a push, pop, flush or control write in the first cycle after that clock edge.

Top module: `rxq_level_irq`

## Requirements
- R1: After reset, the occupancy is 0, both enable bits are 0, both trigger codes and both stored trigger-enable bits are 0, `lvl_stat` is 0, `irq` is 0 and `pop_data` is 0.
- R2: The queue holds up to DEPTH (default 16) characters and returns them in push order. `rx_level` (5 bits) is the occupancy, `rx_not_empty` means occupancy > 0, and `rx_full` means occupancy == DEPTH. `pop_data` shows the oldest character, and a `pop_req` in a cycle removes it at that clock edge.
- R3: A push while the queue is full is dropped: the occupancy stays at DEPTH and the queued contents are unchanged.
- R4: While the queue is empty, `pop_data` reads 0 and a pop leaves the occupancy at 0.
- R5: A 1 on `flush` empties the queue at that clock edge. A push in the same cycle is discarded. `irq` reflects the empty queue in the next cycle.
- R6: The receive trigger condition fires for code 4'b0000 when occupancy >= 1, for 4'b0001 when occupancy >= 2, and for 4'b1111 when occupancy == DEPTH.
- R7: The transmit trigger condition fires for code 4'b0000 when occupancy == 0, for 4'b0001 when occupancy == 1, and for 4'b1111 when occupancy <= DEPTH-1.
- R8: Every other trigger code (4'b0010 to 4'b1110) never fires, for either direction.
- R9: Enable bit i (bit 0 = transmit, bit 1 = receive) becomes 1 after a cycle with `ie_set[i]`=1 and becomes 0 after a cycle with `ie_clr[i]`=1. If both are 1 in the same cycle, the clear wins. With both strobes at 0, the bit holds its value.
- R10: `lvl_stat[i]` equals enable bit i ANDed with that direction's trigger condition (bit 0 = transmit, bit 1 = receive). `irq` is the OR of the two `lvl_stat` bits.
- R11: The trigger codes and the trigger-enable bits (`trig_en_q`, bit 0 = transmit, bit 1 = receive) load from the `cfg_*` inputs only in a cycle with `cfg_we`=1, and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Push request from the receiver |
| push_data | input | 8 | Character to push |
| pop_req | input | 1 | Remove the oldest character at this clock edge |
| pop_data | output | 8 | Oldest character, or 0 when the queue is empty |
| flush | input | 1 | Write-one strobe that empties the queue |
| cfg_we | input | 1 | Loads the trigger codes and trigger-enable bits |
| cfg_rx_code | input | 4 | Receive trigger code |
| cfg_tx_code | input | 4 | Transmit trigger code |
| cfg_trig_en | input | 2 | Trigger-enable bits to store (bit 0 transmit, bit 1 receive) |
| ie_set | input | 2 | Write-one set strobes for the interrupt enables |
| ie_clr | input | 2 | Write-one clear strobes for the interrupt enables |
| trig_en_q | output | 2 | Stored trigger-enable bits |
| ie_q | output | 2 | Interrupt enable bits |
| lvl_stat | output | 2 | Masked level status (bit 0 transmit, bit 1 receive) |
| irq | output | 1 | Combined interrupt |
| rx_level | output | 5 | Queue occupancy |
| rx_not_empty | output | 1 | Occupancy is above zero |
| rx_full | output | 1 | Occupancy equals DEPTH |

## Verification
The bench builds the block with its default values: DEPTH 16 and 8-bit data. At that size it can visit every occupancy from 0 to 16. At each occupancy it applies all sixteen trigger codes to both directions, which covers the meaningful codes, every unused code and every edge of the full and one-short-of-full comparisons. Filling the queue completely also lets the bench try the dropped push at full, check the whole push order on drain, and test pops and flushes at both extremes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned TRIG_CODE_W = 4;
  localparam logic [TRIG_CODE_W-1:0] TRIG_FIRST = 4'b0000;
  localparam logic [TRIG_CODE_W-1:0] TRIG_SECOND = 4'b0001;
  localparam logic [TRIG_CODE_W-1:0] TRIG_LAST = 4'b1111;

  localparam int unsigned DIR_TX = 0;
  localparam int unsigned DIR_RX = 1;

  // Receive side: fires as the queue fills.
  function automatic logic rx_trig_hit(input logic [TRIG_CODE_W-1:0] code,
                                       input int unsigned lvl,
                                       input int unsigned full_lvl);
    logic hit;
    unique case (code)
      TRIG_FIRST:  hit = (lvl >= 1);
      TRIG_SECOND: hit = (lvl >= 2);
      TRIG_LAST:   hit = (lvl == full_lvl);
      default:     hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Transmit side: fires as the queue drains.
  function automatic logic tx_trig_hit(input logic [TRIG_CODE_W-1:0] code,
                                       input int unsigned lvl,
                                       input int unsigned full_lvl);
    logic hit;
    unique case (code)
      TRIG_FIRST:  hit = (lvl == 0);
      TRIG_SECOND: hit = (lvl == 1);
      TRIG_LAST:   hit = (lvl + 1 <= full_lvl);
      default:     hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  input  logic              flush,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  level,
  output logic              push_acc,
  output logic              pop_acc
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic is_empty, is_full;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign is_empty = (count == '0);
  assign is_full  = (count == FULL_LVL);
  assign push_acc = push_valid && !is_full && !flush;
  assign pop_acc  = pop_req && !is_empty && !flush;
  assign head_data = is_empty ? '0 : mem[rd_ptr];
  assign level = count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_acc) wr_ptr <= ptr_next(wr_ptr);
      if (pop_acc)  rd_ptr <= ptr_next(rd_ptr);
      unique case ({push_acc, pop_acc})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/rxq_trig_eval.sv
module rxq_trig_eval #(
  parameter int unsigned DEPTH = 16,
  parameter bit IS_RX = 1'b1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned CW = rxq_pkg::TRIG_CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CW-1:0]    cfg_code,
  input  logic             cfg_en,
  input  logic [CNT_W-1:0] level,
  output logic             trig_en_q,
  output logic             hit
);
  logic [CW-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= '0;
      trig_en_q <= 1'b0;
    end else if (cfg_we) begin
      code_q    <= cfg_code;
      trig_en_q <= cfg_en;
    end
  end

  generate
    if (IS_RX) begin : g_rx
      assign hit = rxq_pkg::rx_trig_hit(code_q, 32'(level), DEPTH);
    end else begin : g_tx
      assign hit = rxq_pkg::tx_trig_hit(code_q, 32'(level), DEPTH);
    end
  endgenerate
endmodule

// File: rtl/rxq_ie_bit.sv
module rxq_ie_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (clr_i) en_q <= 1'b0;
    else if (set_i) en_q <= 1'b1;
  end
endmodule

// File: rtl/rxq_level_irq.sv
module rxq_level_irq #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned CW = rxq_pkg::TRIG_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  input  logic              flush,
  input  logic              cfg_we,
  input  logic [CW-1:0]     cfg_rx_code,
  input  logic [CW-1:0]     cfg_tx_code,
  input  logic [1:0]        cfg_trig_en,
  input  logic [1:0]        ie_set,
  input  logic [1:0]        ie_clr,
  output logic [1:0]        trig_en_q,
  output logic [1:0]        ie_q,
  output logic [1:0]        lvl_stat,
  output logic              irq,
  output logic [CNT_W-1:0]  rx_level,
  output logic              rx_not_empty,
  output logic              rx_full
);
  logic push_acc, pop_acc;
  logic [1:0] trig_hit;
  logic [CW-1:0] cfg_code [2];

  assign cfg_code[rxq_pkg::DIR_TX] = cfg_tx_code;
  assign cfg_code[rxq_pkg::DIR_RX] = cfg_rx_code;

  rxq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_data(push_data),
    .pop_req(pop_req), .flush(flush),
    .head_data(pop_data), .level(rx_level),
    .push_acc(push_acc), .pop_acc(pop_acc)
  );

  generate
    for (genvar d = 0; d < 2; d++) begin : g_dir
      rxq_trig_eval #(.DEPTH(DEPTH), .IS_RX(d == rxq_pkg::DIR_RX)) trig_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_code(cfg_code[d]), .cfg_en(cfg_trig_en[d]),
        .level(rx_level), .trig_en_q(trig_en_q[d]), .hit(trig_hit[d])
      );
      rxq_ie_bit ie_i (
        .clk(clk), .rst_n(rst_n),
        .set_i(ie_set[d]), .clr_i(ie_clr[d]), .en_q(ie_q[d])
      );
      assign lvl_stat[d] = ie_q[d] & trig_hit[d];
    end
  endgenerate

  assign irq = |lvl_stat;
  assign rx_not_empty = (rx_level != '0);
  assign rx_full = (rx_level == CNT_W'(DEPTH));
endmodule

// File: rtl/rxq_level_irq_chk.sv
module rxq_level_irq_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_valid,
  input logic              pop_req,
  input logic              flush,
  input logic [1:0]        ie_set,
  input logic [1:0]        ie_clr,
  input logic [1:0]        ie_q,
  input logic              irq,
  input logic [CNT_W-1:0]  rx_level,
  input logic              rx_full,
  input logic              rx_not_empty,
  input logic [DATA_W-1:0] pop_data,
  input logic              push_acc,
  input logic              pop_acc
);
  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= CNT_W'(DEPTH));

  assert_push_moves_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc && !pop_acc |=> rx_level == $past(rx_level) + 1'b1);

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && push_valid && !pop_req && !flush |=> rx_full && $stable(rx_level));

  assert_empty_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_not_empty |-> pop_data == '0);

  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> rx_level == '0);

  generate
    for (genvar d = 0; d < 2; d++) begin : g_ie
      assert_ie_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ie_clr[d] |=> !ie_q[d]);
      assert_ie_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ie_set[d] && !ie_clr[d] |=> ie_q[d]);
      assert_ie_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_set[d] && !ie_clr[d] |=> $stable(ie_q[d]));
    end
  endgenerate

  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie_q != 2'b00);
endmodule

bind rxq_level_irq rxq_level_irq_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop_req(pop_req),
  .flush(flush), .ie_set(ie_set), .ie_clr(ie_clr), .ie_q(ie_q), .irq(irq),
  .rx_level(rx_level), .rx_full(rx_full), .rx_not_empty(rx_not_empty),
  .pop_data(pop_data), .push_acc(push_acc), .pop_acc(pop_acc)
);

// File: tb/rxq_level_irq_tb_top.sv
module rxq_level_irq_tb_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic [7:0] push_data = '0;
  logic pop_req = 1'b0;
  logic [7:0] pop_data;
  logic flush = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_rx_code = '0;
  logic [3:0] cfg_tx_code = '0;
  logic [1:0] cfg_trig_en = '0;
  logic [1:0] ie_set = '0;
  logic [1:0] ie_clr = '0;
  logic [1:0] trig_en_q, ie_q, lvl_stat;
  logic irq;
  logic [4:0] rx_level;
  logic rx_not_empty, rx_full;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rxq_level_irq dut_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .pop_req(pop_req), .pop_data(pop_data), .flush(flush), .cfg_we(cfg_we),
    .cfg_rx_code(cfg_rx_code), .cfg_tx_code(cfg_tx_code), .cfg_trig_en(cfg_trig_en),
    .ie_set(ie_set), .ie_clr(ie_clr), .trig_en_q(trig_en_q), .ie_q(ie_q),
    .lvl_stat(lvl_stat), .irq(irq), .rx_level(rx_level),
    .rx_not_empty(rx_not_empty), .rx_full(rx_full)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Independent restatement of the trigger tables.
  function automatic bit exp_rx(input int code, input int lvl);
    if (code == 0) return lvl != 0;
    if (code == 1) return lvl > 1;
    if (code == 15) return lvl == DEPTH;
    return 1'b0;
  endfunction

  function automatic bit exp_tx(input int code, input int lvl);
    if (code == 0) return lvl == 0;
    if (code == 1) return lvl == 1;
    if (code == 15) return lvl < DEPTH;
    return 1'b0;
  endfunction

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37) + 5);
  endfunction

  task automatic write_cfg(input int rxc, input int txc, input logic [1:0] en);
    cfg_rx_code = 4'(rxc);
    cfg_tx_code = 4'(txc);
    cfg_trig_en = en;
    cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    push_data = d;
    push_valid = 1'b1;
    tick();
    push_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 level", int'(rx_level), 0);
    check("R1 ie", int'(ie_q), 0);
    check("R1 trig_en", int'(trig_en_q), 0);
    check("R1 lvl_stat", int'(lvl_stat), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 pop_data", int'(pop_data), 0);

    ie_set = 2'b11;
    tick();
    ie_set = 2'b00;
    check("R9 set both", int'(ie_q), 3);

    // Sweep every occupancy and every code (R6, R7, R8, R10, R2)
    for (int l = 0; l <= DEPTH; l++) begin
      check("R2 level", int'(rx_level), l);
      check("R2 not_empty", int'(rx_not_empty), int'(l != 0));
      check("R2 full", int'(rx_full), int'(l == DEPTH));
      for (int c = 0; c < 16; c++) begin
        write_cfg(c, c, 2'b00);
        check((c == 0 || c == 1 || c == 15) ? "R6 R7 rx/tx level status" : "R8 unused code",
              int'(lvl_stat), int'({exp_rx(c, l), exp_tx(c, l)}));
        check("R10 irq", int'(irq), int'(exp_rx(c, l) || exp_tx(c, l)));
      end
      if (l < DEPTH) push(pat(l));
    end

    // R3 push at full dropped
    push(8'hEE);
    check("R3 level at full", int'(rx_level), DEPTH);
    // R2 drain in order (R3: dropped byte must not appear)
    for (int k = 0; k < DEPTH; k++) begin
      check("R2 order", int'(pop_data), int'(pat(k)));
      pop_req = 1'b1;
      tick();
      pop_req = 1'b0;
    end
    check("R2 drained", int'(rx_level), 0);
    // R4 pop empty
    check("R4 empty data", int'(pop_data), 0);
    pop_req = 1'b1;
    tick();
    pop_req = 1'b0;
    check("R4 empty pop level", int'(rx_level), 0);
    check("R4 empty pop data", int'(pop_data), 0);

    // R5 flush with concurrent push
    push(8'h11);
    push(8'h22);
    push(8'h33);
    write_cfg(0, 2, 2'b00);
    check("R5 irq before flush", int'(irq), 1);
    push_data = 8'h44;
    push_valid = 1'b1;
    flush = 1'b1;
    tick();
    push_valid = 1'b0;
    flush = 1'b0;
    check("R5 level after flush", int'(rx_level), 0);
    check("R5 irq after flush", int'(irq), 0);
    check("R5 data after flush", int'(pop_data), 0);

    // R9 strobe behaviour
    tick();
    check("R9 hold", int'(ie_q), 3);
    ie_clr = 2'b01;
    tick();
    ie_clr = 2'b00;
    check("R9 clear tx", int'(ie_q), 2);
    ie_set = 2'b10;
    ie_clr = 2'b10;
    tick();
    ie_set = 2'b00;
    ie_clr = 2'b00;
    check("R9 clear wins", int'(ie_q), 0);

    // R10 masking by enable
    push(8'h55);
    write_cfg(0, 15, 2'b00);
    check("R10 masked off", int'(lvl_stat), 0);
    check("R10 irq off", int'(irq), 0);
    ie_set = 2'b01;
    tick();
    ie_set = 2'b00;
    check("R10 tx only", int'(lvl_stat), 1);
    check("R10 irq tx", int'(irq), 1);

    // R11 config loads only on cfg_we
    write_cfg(2, 2, 2'b10);
    check("R11 trig_en load", int'(trig_en_q), 2);
    check("R11 code load", int'(lvl_stat), 0);
    cfg_rx_code = 4'd0;
    cfg_tx_code = 4'd15;
    cfg_trig_en = 2'b01;
    tick();
    tick();
    check("R11 trig_en held", int'(trig_en_q), 2);
    check("R11 codes held", int'(lvl_stat), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule